// File: doc/BRIEF.md
# Byte-Lane Static Memory Emulator

This block is a clocked, synthesizable stand-in for a 16-bit wide static memory that has the usual active-low control pins: chip select, output enable, write enable, and one enable for each byte. A memory-controller testbench connects to it as if it were the real part. The emulator does not model analog timing. It samples the controls on each rising clock edge and decides, for each byte lane, whether that lane is written, driven onto the read bus, or left floating.

A drive-enable output is provided for each lane. It shows which half of the data bus the emulator owns in the current cycle. A controller bench uses it to catch bus contention and wrong lane steering. The depth is set by the address-width parameter. A width of 16 gives the full 65,536-word array, and the default is smaller so that elaboration stays quick.

Top module: `sram_emu`

## Requirements
- R1: The array holds 2**ADDR_W words of 16 bits. Lane 0 is data bits 7:0 and is gated by `lb_n_i`. Lane 1 is bits 15:8 and is gated by `ub_n_i`. A word written with both lanes enabled reads back unchanged.
- R2: When `cs_n_i` is high, `drv_o` is 00 and `rdata_o` is zero in the following cycle, and nothing is written, whatever the other inputs are.
- R3: When `cs_n_i`=0, `we_n_i`=1 and `oe_n_i`=0, each lane whose byte enable is low drives the stored byte at `addr_i`. Any other lane has its `drv_o` bit at 0.
- R4: When `cs_n_i`=0 and `we_n_i`=0, each lane whose byte enable is low stores the matching byte of `wdata_i`, and a lane whose enable is high keeps its old contents. In such a cycle no lane drives, whatever `oe_n_i` is. This also covers the case where chip select falls after write enable has fallen.
- R5: When `cs_n_i`=0 and `we_n_i`=1, both lanes float if `oe_n_i` is high or if both byte enables are high.
- R6: A write needs chip select low, write enable low and at least one byte enable low, all in the same sampled cycle. If both byte enables are high, the array is left unchanged.
- R7: `drv_o` and `rdata_o` are registered and reflect the controls sampled on the previous rising edge. After a write, driving resumes in the cycle after `we_n_i` is sampled high.
- R8: A byte of `rdata_o` whose lane is not driving reads as zero.
- R9: While `rst_n` is low, `drv_o` and `rdata_o` are held at zero.
- R10: Each address holds its own word. This includes address 0 and the highest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the output registers |
| addr_i | input | ADDR_W | Word address |
| cs_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| ub_n_i | input | 1 | Upper byte (15:8) enable, active low |
| lb_n_i | input | 1 | Lower byte (7:0) enable, active low |
| wdata_i | input | 16 | Write data from the controller |
| rdata_o | output | 16 | Read data; undriven lanes are zero |
| drv_o | output | 2 | Per-lane drive enable, bit 0 = low lane |

## Verification
Reads and writes are tried with both byte enables low, with only the lower enable low, and with only the upper enable low. These three cases show whether lane steering and per-lane write masking are correct or whether the two lanes have been swapped or merged. The bench also applies control sets that look close to a read or a write but differ in one pin: chip select high, output enable high, both byte enables high, and write enable low with output enable low. Each of these checks that one particular pin vetoes drive or write on its own. A read-write-read sequence and a write that is held while chip select falls late check bus turnaround. Separate words at address 0, at the top address and in the middle check that addresses do not alias one another.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_READ    = 2'd1,
        MODE_WRITE   = 2'd2,
        MODE_QUIET   = 2'd3
    } acc_mode_e;

    typedef struct packed {
        acc_mode_e         mode;
        logic [LANES-1:0]  lane_wr;
        logic [LANES-1:0]  lane_rd;
    } lane_ctrl_t;

endpackage

// File: rtl/sram_emu_decode.sv
module sram_emu_decode
    import sram_emu_pkg::*;
(
    input  logic             cs_n_i,
    input  logic             oe_n_i,
    input  logic             we_n_i,
    input  logic [LANES-1:0] be_n_i,
    output logic [LANES-1:0] lane_wr_o,
    output logic [LANES-1:0] lane_rd_o
);

    lane_ctrl_t ctrl_d;
    logic [LANES-1:0] be_on;

    always_comb begin
        be_on          = ~be_n_i;
        ctrl_d.mode    = MODE_QUIET;
        ctrl_d.lane_wr = '0;
        ctrl_d.lane_rd = '0;

        // Chip select dominates; write enable outranks output enable.
        if (cs_n_i) begin
            ctrl_d.mode = MODE_STANDBY;
        end else if (!we_n_i) begin
            ctrl_d.mode = (be_on != '0) ? MODE_WRITE : MODE_QUIET;
        end else if (!oe_n_i && (be_on != '0)) begin
            ctrl_d.mode = MODE_READ;
        end

        case (ctrl_d.mode)
            MODE_WRITE: ctrl_d.lane_wr = be_on;
            MODE_READ:  ctrl_d.lane_rd = be_on;
            default: begin
                ctrl_d.lane_wr = '0;
                ctrl_d.lane_rd = '0;
            end
        endcase
    end

    assign lane_wr_o = ctrl_d.lane_wr;
    assign lane_rd_o = ctrl_d.lane_rd;

endmodule

// File: rtl/sram_emu_lane.sv
module sram_emu_lane #(
    parameter int ADDR_W = 11,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [LANE_W-1:0] wdata_i,
    output logic [LANE_W-1:0] rdata_o,
    output logic              drive_o
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic              drive;
        logic [LANE_W-1:0] rdata;
    } lane_reg_t;

    logic [LANE_W-1:0] mem_q [DEPTH];
    lane_reg_t reg_d, reg_q;

    always_comb begin
        reg_d.drive = rd_en_i;
        reg_d.rdata = rd_en_i ? mem_q[addr_i] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    // Array storage carries no reset, as in a real static memory.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = reg_q.rdata;
    assign drive_o = reg_q.drive;

    // R4: the decoder must never ask one lane to write and drive together.
    p_wr_rd_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && rd_en_i));

    // R8: a lane that is not driving contributes zero to the read bus.
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_o |-> (rdata_o == '0));

endmodule

// File: rtl/sram_emu.sv
module sram_emu
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cs_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic              ub_n_i,
    input  logic              lb_n_i,
    input  logic [15:0]       wdata_i,
    output logic [15:0]       rdata_o,
    output logic [1:0]        drv_o
);

    logic [LANES-1:0] be_n;
    logic [LANES-1:0] lane_wr;
    logic [LANES-1:0] lane_rd;

    assign be_n = {ub_n_i, lb_n_i};

    sram_emu_decode i_decode (
        .cs_n_i    (cs_n_i),
        .oe_n_i    (oe_n_i),
        .we_n_i    (we_n_i),
        .be_n_i    (be_n),
        .lane_wr_o (lane_wr),
        .lane_rd_o (lane_rd)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_emu_lane #(
            .ADDR_W (ADDR_W),
            .LANE_W (LANE_W)
        ) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr_i  (addr_i),
            .wr_en_i (lane_wr[g]),
            .rd_en_i (lane_rd[g]),
            .wdata_i (wdata_i[g*LANE_W +: LANE_W]),
            .rdata_o (rdata_o[g*LANE_W +: LANE_W]),
            .drive_o (drv_o[g])
        );
    end

    // R2: a deselected cycle is followed by a fully floating bus.
    p_standby_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n_i) |-> (drv_o == 2'b00));

    // R4: a selected write cycle is followed by no drive at all.
    p_write_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cs_n_i && !we_n_i) |-> (drv_o == 2'b00));

    // R3: a read cycle drives exactly the enabled lanes.
    p_read_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cs_n_i && we_n_i && !oe_n_i) |-> (drv_o == ~$past({ub_n_i, lb_n_i})));

    // R5: output enable high keeps both lanes floating.
    p_oe_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cs_n_i && we_n_i && oe_n_i) |-> (drv_o == 2'b00));

endmodule

// File: tb/test_sram_emu.sv
module test_sram_emu;

    localparam int ADDR_W = 11;
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              cs_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              we_n = 1'b1;
    logic              ub_n = 1'b1;
    logic              lb_n = 1'b1;
    logic [15:0]       wdata = '0;
    logic [15:0]       rdata;
    logic [1:0]        drv;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    sram_emu #(.ADDR_W(ADDR_W)) i_sram_emu (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr),
        .cs_n_i  (cs_n),
        .oe_n_i  (oe_n),
        .we_n_i  (we_n),
        .ub_n_i  (ub_n),
        .lb_n_i  (lb_n),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .drv_o   (drv)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; result of the next rising edge is visible at the following falling edge.
    task automatic apply(input logic c, input logic o, input logic w, input logic u, input logic l,
                         input logic [ADDR_W-1:0] a, input logic [15:0] d);
        cs_n = c; oe_n = o; we_n = w; ub_n = u; lb_n = l; addr = a; wdata = d;
        @(negedge clk);
    endtask

    task automatic wr(input logic u, input logic l, input logic [ADDR_W-1:0] a, input logic [15:0] d);
        apply(1'b0, 1'b1, 1'b0, u, l, a, d);
    endtask

    task automatic rd(input logic u, input logic l, input logic [ADDR_W-1:0] a);
        apply(1'b0, 1'b0, 1'b1, u, l, a, 16'h0000);
    endtask

    task automatic t_reset;
        check("R9 drv in reset", {14'd0, drv}, 16'h0000);
        check("R9 rdata in reset", rdata, 16'h0000);
    endtask

    task automatic t_word;
        wr(1'b0, 1'b0, 11'd5, 16'hA55A);
        check("R4 no drive in write", {14'd0, drv}, 16'h0000);
        rd(1'b0, 1'b0, 11'd5);
        check("R3 word drive", {14'd0, drv}, 16'h0003);
        check("R1 word readback", rdata, 16'hA55A);
    endtask

    task automatic t_bytes;
        wr(1'b1, 1'b0, 11'd5, 16'h1234);
        wr(1'b0, 1'b1, 11'd5, 16'hC3FF);
        rd(1'b0, 1'b0, 11'd5);
        check("R4 lane masked writes", rdata, 16'hC334);
        rd(1'b1, 1'b0, 11'd5);
        check("R3 low lane drive", {14'd0, drv}, 16'h0001);
        check("R8 low lane data", rdata, 16'h0034);
        rd(1'b0, 1'b1, 11'd5);
        check("R3 high lane drive", {14'd0, drv}, 16'h0002);
        check("R8 high lane data", rdata, 16'hC300);
    endtask

    task automatic t_standby;
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd5, 16'hFFFF);
        check("R2 standby write drv", {14'd0, drv}, 16'h0000);
        apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'd5, 16'h0000);
        check("R2 standby read drv", {14'd0, drv}, 16'h0000);
        check("R2 standby rdata", rdata, 16'h0000);
        rd(1'b0, 1'b0, 11'd5);
        check("R2 no write when deselected", rdata, 16'hC334);
    endtask

    task automatic t_float;
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'd5, 16'h0000);
        check("R5 oe high floats", {14'd0, drv}, 16'h0000);
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 11'd5, 16'h0000);
        check("R5 no byte enable floats", {14'd0, drv}, 16'h0000);
        check("R8 floating rdata", rdata, 16'h0000);
    endtask

    task automatic t_no_be;
        apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 11'd5, 16'h0000);
        check("R6 drv with no byte enable", {14'd0, drv}, 16'h0000);
        rd(1'b0, 1'b0, 11'd5);
        check("R6 array unchanged", rdata, 16'hC334);
    endtask

    task automatic t_turn;
        rd(1'b0, 1'b0, 11'd5);
        check("R7 read drives", {14'd0, drv}, 16'h0003);
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd9, 16'h0F0F);
        check("R4 write overrides oe", {14'd0, drv}, 16'h0000);
        rd(1'b0, 1'b0, 11'd9);
        check("R7 drive resumes", {14'd0, drv}, 16'h0003);
        check("R7 data after turnaround", rdata, 16'h0F0F);
        apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 11'd9, 16'h7777);
        check("R4 late select phase 1", {14'd0, drv}, 16'h0000);
        apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 11'd9, 16'h7777);
        check("R4 late select phase 2", {14'd0, drv}, 16'h0000);
        rd(1'b0, 1'b0, 11'd9);
        check("R4 late select wrote low lane", rdata, 16'h0F77);
    endtask

    task automatic t_addr;
        wr(1'b0, 1'b0, 11'd0, 16'h1111);
        wr(1'b0, 1'b0, TOP_ADDR, 16'hEEEE);
        rd(1'b0, 1'b0, 11'd0);
        check("R10 address zero", rdata, 16'h1111);
        rd(1'b0, 1'b0, TOP_ADDR);
        check("R10 top address", rdata, 16'hEEEE);
        rd(1'b0, 1'b0, 11'd9);
        check("R10 middle untouched", rdata, 16'h0F77);
        rd(1'b0, 1'b0, 11'd5);
        check("R1 earlier word kept", rdata, 16'hC334);
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_word;
        t_bytes;
        t_standby;
        t_float;
        t_no_be;
        t_turn;
        t_addr;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule